// File: doc/BRIEF.md
# Clock Output Gating and Pin-Mode Multiplexer

This block sits between free-running CPU, AGP and PCI domain clocks and the output pins of a clock generator. It fans each domain out to a bank of outputs: four CPU clocks, twelve memory clocks, five PCI clocks and one AGP clock. Every output has its own gate, and every gate opens or closes only while its clock is low, so a pin never shows a shortened pulse.

Two latched strap values configure the block. The memory-source strap picks the clock behind all twelve memory outputs: the CPU clock or the AGP clock. The mode strap decides what four shared pins do. They are either memory clocks 4 to 7, or active-low inputs that stop the CPU and memory group, the PCI group or the AGP output, or power down every output. A parallel vector of disable bits, one per output, comes from a serial register block outside this module. Each bit turns its output off on its own.

Top module: `clk_gate_mux`

## Requirements
- R1: While `rst_n` is low, every clock output is low.
- R2: With `strap_mem_src` = 1, each enabled memory output pulses once per CPU clock cycle. With `strap_mem_src` = 0, each enabled memory output pulses once per AGP clock cycle.
- R3: With `strap_mode` = 1, memory outputs 4 to 7 run like the other memory outputs, and `shared_pin_i` has no effect on any output.
- R4: With `strap_mode` = 0, memory outputs 4 to 7 stay low. The bits of `shared_pin_i` act as active-low controls: bit 0 stops AGP, bit 1 powers down, bit 2 stops CPU, bit 3 stops PCI.
- R5: In mode 0, `shared_pin_i[2]` = 0 holds all CPU outputs and all memory outputs low.
- R6: In mode 0, `shared_pin_i[3]` = 0 holds all PCI outputs low.
- R7: In mode 0, `shared_pin_i[0]` = 0 holds the AGP output low.
- R8: In mode 0, `shared_pin_i[1]` = 0 holds every clock output low, whatever the other controls say.
- R9: Bit i of `dis_cpu_i`, `dis_mem_i` or `dis_pci_i` at 1 holds output i of that group low. `dis_agp_i` at 1 holds the AGP output low. Outputs whose disable bit is 0 are not affected.
- R10: A change of any stop, power-down or disable input takes effect at the next falling edge of the affected clock. An output is never high while its clock is low, and it never falls while its clock is high.
- R11: Each bit of `shared_oe_o` equals `strap_mode`. A 1 means the shared pin drives a memory clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Free-running CPU domain clock |
| clk_agp | input | 1 | Free-running AGP domain clock |
| clk_pci | input | 1 | Free-running PCI domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_mode | input | 1 | Latched mode strap: 1 = shared pins are clocks, 0 = shared pins are controls |
| strap_mem_src | input | 1 | Latched source strap: 1 = memory clocks from CPU clock, 0 = from AGP clock |
| shared_pin_i | input | 4 | Sensed level of the four shared pins |
| dis_cpu_i | input | 4 | Per-output disables for the CPU outputs |
| dis_mem_i | input | 12 | Per-output disables for the memory outputs |
| dis_pci_i | input | 5 | Per-output disables for the PCI outputs |
| dis_agp_i | input | 1 | Disable for the AGP output |
| cpu_clk_o | output | 4 | Gated CPU clocks |
| mem_clk_o | output | 12 | Gated memory clocks |
| pci_clk_o | output | 5 | Gated PCI clocks |
| agp_clk_o | output | 1 | Gated AGP clock |
| shared_oe_o | output | 4 | Output-enable for the four shared pins |

## Verification
The only state in the block is one enable flop per output. A wrong enable bit therefore shows up at the port in the next high phase of that output's clock. The output is either missing or present against the expected pattern, which puts a fault within one clock period of the input that caused it. A flop clocked on the wrong edge, or a gate that is not held through the high phase, shows up as an output edge while its clock is steady. A mis-wired mode decode or source select shows up as a wrong edge count on the memory group within a few cycles.

// File: rtl/clk_gate_mux.sv
module clk_gate_mux #(
  parameter int N_CPU = 4,
  parameter int N_MEM = 12,
  parameter int N_PCI = 5
) (
  input  logic             clk_cpu,
  input  logic             clk_agp,
  input  logic             clk_pci,
  input  logic             rst_n,
  input  logic             strap_mode,
  input  logic             strap_mem_src,
  input  logic [3:0]       shared_pin_i,
  input  logic [N_CPU-1:0] dis_cpu_i,
  input  logic [N_MEM-1:0] dis_mem_i,
  input  logic [N_PCI-1:0] dis_pci_i,
  input  logic             dis_agp_i,
  output logic [N_CPU-1:0] cpu_clk_o,
  output logic [N_MEM-1:0] mem_clk_o,
  output logic [N_PCI-1:0] pci_clk_o,
  output logic             agp_clk_o,
  output logic [3:0]       shared_oe_o
);

  localparam int SH_LO = 4;
  localparam int SH_N  = 4;
  localparam logic [N_MEM-1:0] SH_MASK = N_MEM'(((1 << SH_N) - 1) << SH_LO);

  logic stop_agp, pwr_dn, stop_cpu, stop_pci;
  assign {stop_pci, stop_cpu, pwr_dn, stop_agp} = strap_mode ? 4'b0000 : ~shared_pin_i;

  logic mem_src;
  assign mem_src = strap_mem_src ? clk_cpu : clk_agp;

  logic [N_CPU-1:0] cpu_req, cpu_en;
  logic [N_MEM-1:0] mem_req, mem_en;
  logic [N_PCI-1:0] pci_req, pci_en;
  logic             agp_req, agp_en;

  assign cpu_req = ~dis_cpu_i & {N_CPU{~(pwr_dn | stop_cpu)}};
  assign mem_req = ~dis_mem_i & ~(strap_mode ? '0 : SH_MASK) & {N_MEM{~(pwr_dn | stop_cpu)}};
  assign pci_req = ~dis_pci_i & {N_PCI{~(pwr_dn | stop_pci)}};
  assign agp_req = ~dis_agp_i & ~(pwr_dn | stop_agp);

  always_ff @(negedge clk_cpu or negedge rst_n)
    if (!rst_n) cpu_en <= '0;
    else        cpu_en <= cpu_req;

  always_ff @(negedge mem_src or negedge rst_n)
    if (!rst_n) mem_en <= '0;
    else        mem_en <= mem_req;

  always_ff @(negedge clk_pci or negedge rst_n)
    if (!rst_n) pci_en <= '0;
    else        pci_en <= pci_req;

  always_ff @(negedge clk_agp or negedge rst_n)
    if (!rst_n) agp_en <= 1'b0;
    else        agp_en <= agp_req;

  assign cpu_clk_o   = {N_CPU{clk_cpu}} & cpu_en;
  assign mem_clk_o   = {N_MEM{mem_src}} & mem_en;
  assign pci_clk_o   = {N_PCI{clk_pci}} & pci_en;
  assign agp_clk_o   = clk_agp & agp_en;
  assign shared_oe_o = {SH_N{strap_mode}};

  always_comb
    if (!rst_n)
      assert_reset_low_R1: assert (cpu_clk_o == '0 && mem_clk_o == '0 && pci_clk_o == '0 && !agp_clk_o);

  assert_cpu_low_phase_R10: assert property (@(posedge clk_cpu) disable iff (!rst_n) cpu_clk_o == '0);
  assert_pci_low_phase_R10: assert property (@(posedge clk_pci) disable iff (!rst_n) pci_clk_o == '0);
  assert_agp_low_phase_R10: assert property (@(posedge clk_agp) disable iff (!rst_n) !agp_clk_o);

  assert_cpu_stop_R5: assert property (@(negedge clk_cpu) disable iff (!rst_n)
    (!strap_mode && !shared_pin_i[2]) |=> cpu_clk_o == '0);
  assert_pci_stop_R6: assert property (@(negedge clk_pci) disable iff (!rst_n)
    (!strap_mode && !shared_pin_i[3]) |=> pci_clk_o == '0);
  assert_agp_stop_R7: assert property (@(negedge clk_agp) disable iff (!rst_n)
    (!strap_mode && !shared_pin_i[0]) |=> !agp_clk_o);
  assert_pwr_dn_R8: assert property (@(negedge clk_pci) disable iff (!rst_n)
    (!strap_mode && !shared_pin_i[1]) |=> pci_clk_o == '0);
  assert_shared_off_R4: assert property (@(negedge mem_src) disable iff (!rst_n)
    !strap_mode |=> mem_clk_o[SH_LO+SH_N-1:SH_LO] == '0);
  assert_cpu_run_R3: assert property (@(negedge clk_cpu) disable iff (!rst_n)
    (strap_mode && dis_cpu_i == '0) |=> cpu_clk_o == '1);
  assert_pci_disable_R9: assert property (@(negedge clk_pci) disable iff (!rst_n)
    dis_pci_i[0] |=> !pci_clk_o[0]);

endmodule

// File: tb/clk_gate_mux_bench.sv
`timescale 1ns/100ps
module clk_gate_mux_bench;
  logic clk_cpu = 0, clk_agp = 0, clk_pci = 0, rst_n = 0;
  logic mode = 1, src = 1;
  logic [3:0] pin = 4'hF;
  logic [3:0] dcpu = '0;
  logic [11:0] dmem = '0;
  logic [4:0] dpci = '0;
  logic dagp = 0;
  logic [3:0] cpu_o; logic [11:0] mem_o; logic [4:0] pci_o; logic agp_o; logic [3:0] oe_o;

  int total = 0, bad = 0;
  string tag = "R1";

  always #5   clk_cpu = ~clk_cpu;
  always #7.5 clk_agp = ~clk_agp;
  always #15  clk_pci = ~clk_pci;

  clk_gate_mux u_clk_gate_mux (
    .clk_cpu(clk_cpu), .clk_agp(clk_agp), .clk_pci(clk_pci), .rst_n(rst_n),
    .strap_mode(mode), .strap_mem_src(src), .shared_pin_i(pin),
    .dis_cpu_i(dcpu), .dis_mem_i(dmem), .dis_pci_i(dpci), .dis_agp_i(dagp),
    .cpu_clk_o(cpu_o), .mem_clk_o(mem_o), .pci_clk_o(pci_o), .agp_clk_o(agp_o),
    .shared_oe_o(oe_o));

  task automatic chk(input string t, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", t, what, act, exp, $time);
    end
  endtask

  // reference model of the requirements
  logic ref_mem;
  assign ref_mem = src ? clk_cpu : clk_agp;
  bit pwr, scpu, spci, sagp;
  always_comb begin
    pwr  = !mode && !pin[1];
    scpu = !mode && !pin[2];
    spci = !mode && !pin[3];
    sagp = !mode && !pin[0];
  end
  logic [3:0] e_cpu = '0; logic [11:0] e_mem = '0; logic [4:0] e_pci = '0; logic e_agp = 0;

  always @(negedge clk_cpu or negedge rst_n)
    if (!rst_n) e_cpu <= '0;
    else for (int i = 0; i < 4; i++) e_cpu[i] <= !pwr && !scpu && !dcpu[i];
  always @(negedge ref_mem or negedge rst_n)
    if (!rst_n) e_mem <= '0;
    else for (int i = 0; i < 12; i++) e_mem[i] <= !pwr && !scpu && !dmem[i] && (mode || i < 4 || i > 7);
  always @(negedge clk_pci or negedge rst_n)
    if (!rst_n) e_pci <= '0;
    else for (int i = 0; i < 5; i++) e_pci[i] <= !pwr && !spci && !dpci[i];
  always @(negedge clk_agp or negedge rst_n)
    if (!rst_n) e_agp <= 0;
    else e_agp <= !pwr && !sagp && !dagp;

  always @(posedge clk_cpu) begin #2; chk(tag, "cpu high", 16'(cpu_o), 16'(e_cpu)); end
  always @(negedge clk_cpu) begin #2; chk(tag, "cpu low R10", 16'(cpu_o), 16'h0); end
  always @(posedge ref_mem) begin #2; chk(tag, "mem high", 16'(mem_o), 16'(e_mem)); end
  always @(negedge ref_mem) begin #2; chk(tag, "mem low R10", 16'(mem_o), 16'h0); end
  always @(posedge clk_pci) begin #2; chk(tag, "pci high", 16'(pci_o), 16'(e_pci)); end
  always @(negedge clk_pci) begin #2; chk(tag, "pci low R10", 16'(pci_o), 16'h0); end
  always @(posedge clk_agp) begin #2; chk(tag, "agp high", 16'(agp_o), 16'(e_agp)); end
  always @(negedge clk_agp) begin #2; chk(tag, "agp low R10", 16'(agp_o), 16'h0); end

  // runt detection R10: an output edge while its clock is steady
  always @(posedge cpu_o[0]) if (!clk_cpu) chk("R10", "cpu0 rise in low phase", 16'h1, 16'h0);
  always @(negedge cpu_o[0]) if (clk_cpu)  chk("R10", "cpu0 fall in high phase", 16'h1, 16'h0);
  always @(posedge pci_o[0]) if (!clk_pci) chk("R10", "pci0 rise in low phase", 16'h1, 16'h0);
  always @(negedge pci_o[0]) if (clk_pci)  chk("R10", "pci0 fall in high phase", 16'h1, 16'h0);
  always @(negedge agp_o)    if (clk_agp)  chk("R10", "agp fall in high phase", 16'h1, 16'h0);

  // edge counters per group
  int a_cpu = 0, x_cpu = 0, a_mem = 0, x_mem = 0, a_pci = 0, x_pci = 0, a_agp = 0, x_agp = 0;
  always @(posedge cpu_o[0]) a_cpu++;
  always @(posedge clk_cpu) if (e_cpu[0]) x_cpu++;
  always @(posedge mem_o[0]) a_mem++;
  always @(posedge ref_mem) if (e_mem[0]) x_mem++;
  always @(posedge pci_o[0]) a_pci++;
  always @(posedge clk_pci) if (e_pci[0]) x_pci++;
  always @(posedge agp_o) a_agp++;
  always @(posedge clk_agp) if (e_agp) x_agp++;

  task automatic phase(input string t, input int n);
    tag = t;
    #(30 * n);
    chk(t, "cpu edges", 16'(a_cpu), 16'(x_cpu));
    chk({t, ",R2"}, "mem edges", 16'(a_mem), 16'(x_mem));
    chk(t, "pci edges", 16'(a_pci), 16'(x_pci));
    chk(t, "agp edges", 16'(a_agp), 16'(x_agp));
  endtask

  initial begin
    #1;
    #60;
    chk("R1", "outputs in reset", 16'({cpu_o, pci_o, agp_o}), 16'h0);
    chk("R1", "mem in reset", 16'(mem_o), 16'h0);
    chk("R11", "oe mode1", 16'(oe_o), 16'hF);
    rst_n = 1;
    phase("R3", 10);
    chk("R2", "mem edges follow cpu clock", 16'(a_mem), 16'(a_cpu));
    pin = 4'h0;
    phase("R3", 10);
    dcpu = 4'b0101; dmem = 12'hA5A; dpci = 5'b10010; dagp = 1;
    phase("R9", 10);
    dcpu = '0; dmem = '0; dpci = '0; dagp = 0;
    phase("R9", 4);
    tag = "R10";
    for (int k = 0; k < 12; k++) begin
      dcpu[0] = ~dcpu[0]; dpci[0] = ~dpci[0]; dagp = ~dagp; dmem[0] = ~dmem[0];
      #30;
    end
    dcpu = '0; dpci = '0; dagp = 0; dmem = '0;
    phase("R10", 4);
    rst_n = 0; mode = 0; src = 0; pin = 4'hF;
    #60;
    chk("R1", "outputs in reset 2", 16'({cpu_o, pci_o, agp_o}), 16'h0);
    chk("R11", "oe mode0", 16'(oe_o), 16'h0);
    rst_n = 1;
    phase("R4", 10);
    pin = 4'b1110; phase("R7", 8);
    pin = 4'b1011; phase("R5", 8);
    pin = 4'b0111; phase("R6", 8);
    pin = 4'b1101; phase("R8", 8);
    pin = 4'b1001; phase("R8", 6);
    pin = 4'hF;    phase("R4", 8);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule